// File: doc/BRIEF.md
# Serial Word Loader with Refill Window

This block takes 40-bit words from a host over a two-wire synchronous serial link, where the host drives both the serial clock and the data line. Both wires are brought into the core clock domain through a synchronizer. Bits are taken on each rising edge of the synchronized serial clock. A completed word goes into a single one-word buffer, which a downstream continuous bit transmitter reads.

The downstream side frees the buffer by pulsing `take`. While a message is in progress, the host then has a limited window, counted in 1 ms ticks, to load the next word. This keeps the outgoing bit stream unbroken for a message of any length. The window length depends on the channel type and the timing mode. If the window runs out, the message is aborted and the block stops accepting words. The `abort_req` input then returns the block to its power-up state.

Top module: `txword_loader`

## Requirements
- R1: Serial bits are assembled most-significant bit first, one bit per rising edge of the synchronized `host_sclk`, sampling `host_sdata`. After the 40th bit the complete word appears on `word_q` and `word_vld` goes to 1.
- R2: While `word_vld` is 1 and `take` is not pulsed, `word_q` holds its value. A word that completes while the buffer is still full is discarded.
- R3: A `take` pulse while `word_vld` is 1 empties the buffer (`word_vld` becomes 0), and the buffer can then accept the next word.
- R4: `busy` goes to 1 when a word is accepted while no message is in progress. A `msg_end` pulse returns `busy` to 0. `busy` and `aborted` are never 1 together.
- R5: Each `take` reloads the window with a length chosen from `chan_voice` and `mode_b` at that moment: (1,0)=60, (1,1)=48, (0,0)=29, (0,1)=23 ticks. While `busy` is 1 and the buffer is empty, the window-length-th `tick_ms` pulse after the `take` sets `aborted` to 1 and clears `busy`. One tick fewer has no effect.
- R6: `tick_ms` pulses have no effect while the buffer holds a word or while `busy` is 0.
- R7: While `aborted` is 1, completed words are discarded and `word_vld` stays 0.
- R8: A one-cycle `abort_req` (active high, synchronous) clears `word_vld`, `busy` and `aborted`, and discards any partly received bits. The next 40 bits form a fresh word.
- R9: With `rst_n` low at a clock edge, `word_vld`, `busy` and `aborted` are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_req | input | 1 | Synchronous message abort, returns link to power-up state |
| host_sclk | input | 1 | Host serial clock, asynchronous to clk |
| host_sdata | input | 1 | Host serial data, MSB first |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| chan_voice | input | 1 | 1 = voice channel, 0 = control channel window |
| mode_b | input | 1 | Selects the shorter timing mode |
| take | input | 1 | Downstream takes the buffered word |
| msg_end | input | 1 | Downstream signals end of message |
| word_q | output | 40 | Buffered word |
| word_vld | output | 1 | Buffer holds a word |
| busy | output | 1 | Message transfer in progress |
| aborted | output | 1 | Message aborted by window expiry |

## Verification
The assertions rely on the downstream side pulsing `take` only in ways that the buffer state explains. They also rely on the host serial clock being slow enough, relative to `clk`, that each level lasts several core cycles. This lets the synchronizer see every edge, with data already stable at each rising edge. The bench meets this by holding each serial clock level for four core cycles and changing data only while the serial clock is low. It drives `tick_ms`, `take`, `msg_end` and `abort_req` as single-cycle pulses set up away from the active clock edge.

// File: rtl/txw_pkg.sv
// Shared definitions for the serial word loader.
// Assumes: one fixed word width for every instance.
package txw_pkg;
    localparam int WORD_BITS = 40;

    // Window class, encoded as {control_not_voice, mode_b}
    typedef enum logic [1:0] {
        WIN_VOICE_A = 2'b00,
        WIN_VOICE_B = 2'b01,
        WIN_CTRL_A  = 2'b10,
        WIN_CTRL_B  = 2'b11
    } win_kind_e;
endpackage

// File: rtl/txw_sync_edge.sv
// Brings the host serial clock and data into the core clock domain and
// flags each rising edge of the serial clock.
// Assumes: each host clock level lasts well over STAGES core cycles, and data
// is stable around the rising edge; both wires use equal-length pipes.
module txw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    output logic rise,
    output logic dat
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] dat_pipe;
    logic              sck_prev;

    // Purpose: multi-stage synchronizers plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            dat_pipe <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sclk_in};
            dat_pipe <= {dat_pipe[STAGES-2:0], sdat_in};
            sck_prev <= sck_pipe[STAGES-1];
        end
    end

    assign rise = sck_pipe[STAGES-1] & ~sck_prev;
    assign dat  = dat_pipe[STAGES-1];
endmodule

// File: rtl/txw_shifter.sv
// Assembles serial bits MSB first and pulses done for one cycle when a full
// word is present on word.
// Assumes: bit_en is a single-cycle strobe per bit; clr drops partial words.
module txw_shifter #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_en,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] count;
    logic [W-1:0]  shreg;
    logic          last_bit;

    assign last_bit = bit_en && (count == CW'(W - 1));

    // Purpose: shift in bits, count them and flag the word-complete cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            shreg <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_bit;
            if (bit_en) begin
                shreg <= {shreg[W-2:0], bit_in};
                count <= last_bit ? '0 : count + 1'b1;
            end
        end
    end

    assign word = shreg;
endmodule

// File: rtl/txw_window.sv
// Down-counter of millisecond ticks. Reloads on request, decrements while
// run is high, and reports expiry on the tick that would take it to zero.
// Assumes: win_val >= 1; tick is a single-cycle pulse.
module txw_window #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             reload,
    input  logic [CNT_W-1:0] win_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt <= CNT_W'(1));

    // Purpose: hold, reload or count down the remaining window
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= win_val;
        end else if (run && tick && cnt > CNT_W'(1)) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/txword_loader.sv
// Top level: serial word input, one-word buffer, message flags and refill
// window supervision.
// Assumes: host serial clock far slower than clk; take/msg_end/tick_ms and
// abort_req are single-cycle pulses in the clk domain.
module txword_loader
    import txw_pkg::*;
#(
    parameter int W           = WORD_BITS,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_VA      = 60,
    parameter int WIN_VB      = 48,
    parameter int WIN_CA      = 29,
    parameter int WIN_CB      = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort_req,
    input  logic         host_sclk,
    input  logic         host_sdata,
    input  logic         tick_ms,
    input  logic         chan_voice,
    input  logic         mode_b,
    input  logic         take,
    input  logic         msg_end,
    output logic [W-1:0] word_q,
    output logic         word_vld,
    output logic         busy,
    output logic         aborted
);
    localparam int MAX_V = (WIN_VA > WIN_VB) ? WIN_VA : WIN_VB;
    localparam int MAX_C = (WIN_CA > WIN_CB) ? WIN_CA : WIN_CB;
    localparam int MAX_W = (MAX_V > MAX_C) ? MAX_V : MAX_C;
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic             bit_rise;
    logic             bit_dat;
    logic             word_done;
    logic [W-1:0]     sh_word;
    logic             accept;
    logic             win_run;
    logic             win_reload;
    logic             expire;
    win_kind_e        kind;
    logic [CNT_W-1:0] win_val;

    txw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (host_sclk),
        .sdat_in (host_sdata),
        .rise    (bit_rise),
        .dat     (bit_dat)
    );

    txw_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (abort_req),
        .bit_en (bit_rise),
        .bit_in (bit_dat),
        .done   (word_done),
        .word   (sh_word)
    );

    // Purpose: choose the refill window length from the channel/mode pins
    always_comb begin
        kind = win_kind_e'({~chan_voice, mode_b});
        unique case (kind)
            WIN_VOICE_A: win_val = CNT_W'(WIN_VA);
            WIN_VOICE_B: win_val = CNT_W'(WIN_VB);
            WIN_CTRL_A:  win_val = CNT_W'(WIN_CA);
            default:     win_val = CNT_W'(WIN_CB);
        endcase
    end

    assign accept     = word_done && !aborted && (!word_vld || take);
    assign win_reload = take && word_vld;
    assign win_run    = busy && !word_vld && !word_done;

    txw_window #(.CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (abort_req),
        .reload  (win_reload),
        .win_val (win_val),
        .run     (win_run),
        .tick    (tick_ms),
        .expire  (expire)
    );

    // Purpose: one-word buffer and message in-progress / aborted flags
    always_ff @(posedge clk) begin
        if (!rst_n || abort_req) begin
            word_q   <= '0;
            word_vld <= 1'b0;
            busy     <= 1'b0;
            aborted  <= 1'b0;
        end else begin
            if (accept) begin
                word_q   <= sh_word;
                word_vld <= 1'b1;
            end else if (take) begin
                word_vld <= 1'b0;
            end

            if (expire) begin
                busy    <= 1'b0;
                aborted <= 1'b1;
            end else if (msg_end) begin
                busy <= 1'b0;
            end else if (accept) begin
                busy <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/txword_loader_chk.sv
// Property checker for txword_loader, attached with bind.
// Assumes: reset is synchronous active-low on rst_n.
module txword_loader_chk #(
    parameter int W = 40
) (
    input logic         clk,
    input logic         rst_n,
    input logic         abort_req,
    input logic         take,
    input logic         word_done,
    input logic [W-1:0] word_q,
    input logic         word_vld,
    input logic         busy,
    input logic         aborted
);
    // R2: an untaken word stays put
    a_r2_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && !take && !abort_req |=> word_vld && $stable(word_q));

    // R3: take with no word arriving empties the buffer
    a_r3_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld && take && !word_done |=> !word_vld);

    // R4: flags are exclusive
    a_r4_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && aborted));

    // R5: abort only ends a message that was in progress
    a_r5_abort_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> $past(busy) && !busy);

    // R6: window cannot expire while the buffer is full
    a_r6_no_expiry_full: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !$rose(aborted));

    // R7: no word accepted while aborted
    a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
        aborted && !abort_req |=> !word_vld);

    // R8: abort request returns to power-up flags
    a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !word_vld && !busy && !aborted);
endmodule

bind txword_loader txword_loader_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_req (abort_req),
    .take      (take),
    .word_done (word_done),
    .word_q    (word_q),
    .word_vld  (word_vld),
    .busy      (busy),
    .aborted   (aborted)
);

// File: tb/tb_txword_loader.sv
module tb_txword_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort_req = 1'b0;
    logic        host_sclk = 1'b0;
    logic        host_sdata = 1'b0;
    logic        tick_ms = 1'b0;
    logic        chan_voice = 1'b0;
    logic        mode_b = 1'b0;
    logic        take = 1'b0;
    logic        msg_end = 1'b0;
    logic [39:0] word_q;
    logic        word_vld;
    logic        busy;
    logic        aborted;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    txword_loader dut (.*);

    function automatic int exp_win(input bit voice, input bit b);
        if (voice) return b ? 48 : 60;
        return b ? 23 : 29;
    endfunction

    function automatic logic [39:0] rand_word();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[39:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bits(input logic [39:0] w, input int nbits);
        for (int i = 39; i > 39 - nbits; i--) begin
            @(negedge clk) host_sdata = w[i];
            repeat (4) @(negedge clk);
            host_sclk = 1'b1;
            repeat (4) @(negedge clk);
            host_sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_ms = 1'b1;
            @(negedge clk) tick_ms = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_take();
        @(negedge clk) take = 1'b1;
        @(negedge clk) take = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_abort();
        @(negedge clk) abort_req = 1'b1;
        @(negedge clk) abort_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [39:0] w;
        logic [39:0] w2;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(word_vld == 1'b0 && busy == 1'b0 && aborted == 1'b0, "R9 reset state",
            {word_vld, busy, aborted}, 3'b000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Random message with several words, refills inside the window
        for (int n = 0; n < 6; n++) begin
            bit v;
            bit b;
            int k;
            w = rand_word();
            if (n == 0) w = 40'h80_0000_0001;
            if (n == 1) w = 40'hFF_FFFF_FFFF;
            send_bits(w, 40);
            chk(word_vld && word_q == w, "R1 word assembled", word_q, w);
            chk(busy == 1'b1, "R4 busy after accept", busy, 1);
            pulse_tick($urandom_range(0, 70));
            chk(aborted == 1'b0 && word_vld, "R6 ticks ignored while full", aborted, 0);
            if (n == 2) begin
                w2 = rand_word();
                send_bits(w2, 40);
                chk(word_vld && word_q == w, "R2 word kept when full", word_q, w);
            end
            v = 1'($urandom_range(0, 1));
            b = 1'($urandom_range(0, 1));
            chan_voice = v;
            mode_b = b;
            pulse_take();
            chk(word_vld == 1'b0, "R3 take empties buffer", word_vld, 0);
            k = $urandom_range(0, exp_win(v, b) - 1);
            if (n == 5) k = exp_win(v, b) - 1;
            pulse_tick(k);
            chk(aborted == 1'b0 && busy == 1'b1, "R5 within window no abort",
                {aborted, busy}, 2'b01);
        end

        @(negedge clk) msg_end = 1'b1;
        @(negedge clk) msg_end = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R4 msg_end clears busy", busy, 0);
        pulse_tick(100);
        chk(aborted == 1'b0, "R6 ticks ignored when idle", aborted, 0);

        // Expiry in each window class; mode changed after take must not matter
        for (int m = 0; m < 4; m++) begin
            bit v;
            bit b;
            v = (m < 2);
            b = m[0];
            w = rand_word();
            send_bits(w, 40);
            chk(busy == 1'b1, "R4 new message busy", busy, 1);
            chan_voice = v;
            mode_b = b;
            pulse_take();
            chan_voice = ~v;
            mode_b = ~b;
            pulse_tick(exp_win(v, b) - 1);
            chk(aborted == 1'b0 && busy == 1'b1, "R5 one tick short", {aborted, busy}, 2'b01);
            pulse_tick(1);
            chk(aborted == 1'b1 && busy == 1'b0, "R5 window expiry", {aborted, busy}, 2'b10);
            send_bits(rand_word(), 40);
            chk(word_vld == 1'b0 && aborted == 1'b1, "R7 word discarded while aborted",
                {word_vld, aborted}, 2'b01);
            pulse_abort();
            chk(word_vld == 1'b0 && busy == 1'b0 && aborted == 1'b0, "R8 abort clears flags",
                {word_vld, busy, aborted}, 3'b000);
        end

        // Partial word then abort: next 40 bits form a fresh word
        w = rand_word();
        send_bits(~w, 17);
        pulse_abort();
        send_bits(w, 40);
        chk(word_vld && word_q == w, "R8 partial bits dropped", word_q, w);
        pulse_take();

        // Reset in the middle of a message
        send_bits(rand_word(), 40);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(word_vld == 1'b0 && busy == 1'b0 && aborted == 1'b0, "R9 reset mid-message",
            {word_vld, busy, aborted}, 3'b000);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule